// File: doc/BRIEF.md
# Byte-laned static memory array

A clocked, synthesizable model of a 16-bit-wide static memory whose word is split into a lower lane (bits 7:0) and an upper lane (bits 15:8). Five active-low controls steer it: a chip select, an output enable, a write enable and one select per byte lane. Together they pick one of several modes: standby, output disabled, a full or single-lane read, or a full or single-lane write. The case where both lane selects are inactive does nothing at all.

The tristate data pins are replaced by a read-data bus and one drive-enable flag per lane. A parent block combines these into its own pad or bus logic. The address input is 18 bits wide. Only the low bits, up to the depth set by a parameter, pick a word; the upper bits are ignored, so addresses alias modulo the depth. Writes are committed on the clock edge that samples a valid write. Read data and drive flags appear one clock after the edge that samples a valid read.

Top module: `bytelane_sram`

## Requirements
- R1: While reset is high, the next clock edge clears both drive flags and the whole read-data bus (rdata = 16'h0000).
- R2: With chip select high (sel_n = 1), neither lane drives one clock later. No word is changed, whatever the other controls are.
- R3: With sel_n = 0, we_n = 1 and oe_n = 1, neither lane drives one clock later.
- R4: With sel_n = 0, we_n = 1 and oe_n = 0, one clock later drv_lo equals the inverse of lo_n and drv_hi equals the inverse of hi_n. Each driving lane carries the stored byte: rdata[7:0] for the lower lane and rdata[15:8] for the upper lane.
- R5: With both lane selects high (lo_n = 1, hi_n = 1), a read or a write drives neither lane and changes no stored byte.
- R6: A write happens only when sel_n = 0, we_n = 0 and at least one lane select is low. Only the lanes whose select is low take their byte from wdata; the other lane keeps its stored value.
- R7: While we_n = 0, oe_n has no effect. Neither lane drives one clock later, and the write happens for either value of oe_n.
- R8: The word index is addr modulo the configured depth (2**DEPTH_W words). Address bits at and above DEPTH_W are ignored.
- R9: A read issued in the cycle right after a write to the same word returns the newly written bytes one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lo_n | input | 1 | Lower lane (bits 7:0) select, active low |
| hi_n | input | 1 | Upper lane (bits 15:8) select, active low |
| addr | input | ADDR_W (18) | Word address |
| wdata | input | 2*LANE_W (16) | Write data |
| rdata | output | 2*LANE_W (16) | Registered read data |
| drv_lo | output | 1 | Lower lane would drive the pins |
| drv_hi | output | 1 | Upper lane would drive the pins |

## Verification
Every visible result (the drive flags, the read bytes, and the clearing done by reset) is due exactly one clock after the edge that samples the controls. A write takes effect on that same edge and can only be seen through a later read. The bench changes inputs 1 ns after a rising edge and samples outputs 1 ns after the next rising edge. Each sample therefore reflects exactly one sampled set of controls. Lanes that are not driving are left out of data comparisons, and "nothing was written" is shown by a full read of the same word afterwards.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY   = 3'd0,
    MODE_OUT_OFF   = 3'd1,
    MODE_READ      = 3'd2,
    MODE_WRITE     = 3'd3,
    MODE_NO_LANES  = 3'd4
  } bls_mode_e;

  localparam int unsigned BLS_LANES = 2;
  localparam int unsigned BLS_LANE_LO = 0;
  localparam int unsigned BLS_LANE_HI = 1;

endpackage

// File: rtl/bls_mode_decode.sv
module bls_mode_decode
  import bls_pkg::*;
#(
  parameter int unsigned LANES = BLS_LANES
) (
  input  logic             sel_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] rd_lanes,
  output logic [LANES-1:0] wr_lanes
);

  bls_mode_e mode;

  always_comb begin
    if (sel_n) begin
      mode = MODE_STANDBY;
    end else if (&lane_n) begin
      mode = MODE_NO_LANES;
    end else if (!we_n) begin
      mode = MODE_WRITE;
    end else if (oe_n) begin
      mode = MODE_OUT_OFF;
    end else begin
      mode = MODE_READ;
    end
  end

  always_comb begin
    rd_lanes = '0;
    wr_lanes = '0;
    unique case (mode)
      MODE_READ:  rd_lanes = ~lane_n;
      MODE_WRITE: wr_lanes = ~lane_n;
      default: begin
        rd_lanes = '0;
        wr_lanes = '0;
      end
    endcase
  end

endmodule

// File: rtl/bls_lane_bank.sv
module bls_lane_bank #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] rbyte
);

  localparam int unsigned WORDS = 1 << IDX_W;

  logic [LANE_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[idx] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbyte <= '0;
    end else if (rd_en) begin
      rbyte <= store[idx];
    end
  end

endmodule

// File: rtl/bls_drive_stage.sv
module bls_drive_stage #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rd_lanes,
  output logic [LANES-1:0] drive_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
    end else begin
      drive_q <= rd_lanes;
    end
  end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DEPTH_W = 6,
  parameter int unsigned LANE_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel_n,
  input  logic                          oe_n,
  input  logic                          we_n,
  input  logic                          lo_n,
  input  logic                          hi_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BLS_LANES*LANE_W-1:0]   wdata,
  output logic [BLS_LANES*LANE_W-1:0]   rdata,
  output logic                          drv_lo,
  output logic                          drv_hi
);

  localparam int unsigned LANES = BLS_LANES;

  logic [LANES-1:0]   lane_n;
  logic [LANES-1:0]   rd_lanes;
  logic [LANES-1:0]   wr_lanes;
  logic [LANES-1:0]   drive_q;
  logic [DEPTH_W-1:0] idx;

  assign lane_n[BLS_LANE_LO] = lo_n;
  assign lane_n[BLS_LANE_HI] = hi_n;
  assign idx = addr[DEPTH_W-1:0];

  generate
    if (ADDR_W > DEPTH_W) begin : g_alias
      logic unused_high_addr;
      assign unused_high_addr = ^addr[ADDR_W-1:DEPTH_W];
    end
  endgenerate

  bls_mode_decode #(.LANES(LANES)) decode_i (
    .sel_n    (sel_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .lane_n   (lane_n),
    .rd_lanes (rd_lanes),
    .wr_lanes (wr_lanes)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      bls_lane_bank #(.IDX_W(DEPTH_W), .LANE_W(LANE_W)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_lanes[g]),
        .rd_en (rd_lanes[g]),
        .idx   (idx),
        .wbyte (wdata[g*LANE_W +: LANE_W]),
        .rbyte (rdata[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  bls_drive_stage #(.LANES(LANES)) drive_i (
    .clk      (clk),
    .rst      (rst),
    .rd_lanes (rd_lanes),
    .drive_q  (drive_q)
  );

  assign drv_lo = drive_q[BLS_LANE_LO];
  assign drv_hi = drive_q[BLS_LANE_HI];

endmodule

// File: rtl/bytelane_sram_chk.sv
module bls_checker #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              lo_n,
  input logic              hi_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              drv_lo,
  input logic              drv_hi
);

  logic unused_chk;
  assign unused_chk = ^{addr, wdata};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!drv_lo && !drv_hi && rdata == '0));

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (!drv_lo && !drv_hi));

  assert_out_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && we_n && oe_n) |=> (!drv_lo && !drv_hi));

  assert_lane_drive_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && we_n && !oe_n) |=> (drv_lo == !$past(lo_n) && drv_hi == !$past(hi_n)));

  assert_no_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    (lo_n && hi_n) |=> (!drv_lo && !drv_hi));

  assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> (!drv_lo && !drv_hi));

endmodule

bind bytelane_sram bls_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (2*LANE_W)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .sel_n  (sel_n),
  .oe_n   (oe_n),
  .we_n   (we_n),
  .lo_n   (lo_n),
  .hi_n   (hi_n),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .drv_lo (drv_lo),
  .drv_hi (drv_hi)
);

// File: tb/bytelane_sram_tb_top.sv
`timescale 1ns/1ps
module bytelane_sram_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        drv_lo, drv_hi;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bytelane_sram dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
    .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drv_lo(drv_lo), .drv_hi(drv_hi)
  );

  typedef struct packed {
    logic        sel_n, oe_n, we_n, lo_n, hi_n;
    logic [17:0] addr;
    logic [15:0] wd;
    logic        elo, ehi;
    logic [15:0] ed;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 18'h00003, 16'hA5C3, 1'b0,1'b0, 16'h0000, 4'd6}, // R6 full write
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'hA5C3, 4'd4}, // R4 full read
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 18'h00003, 16'h1177, 1'b0,1'b0, 16'h0000, 4'd7}, // R7 low write, oe_n=0
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'hA577, 4'd6}, // R6 high lane kept
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 18'h00003, 16'h88EE, 1'b0,1'b0, 16'h0000, 4'd6}, // R6 high write
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'h8877, 4'd9}, // R9 read after write
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 18'h00003, 16'h0000, 1'b1,1'b0, 16'h0077, 4'd4}, // R4 low lane only
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 18'h00003, 16'h0000, 1'b0,1'b1, 16'h8800, 4'd4}, // R4 high lane only
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 18'h00003, 16'hFFFF, 1'b0,1'b0, 16'h0000, 4'd2}, // R2 standby write try
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'h8877, 4'd2}, // R2 word unchanged
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b0,1'b0, 16'h0000, 4'd3}, // R3 output off
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 18'h00003, 16'h0000, 1'b0,1'b0, 16'h0000, 4'd5}, // R5 write no lanes
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 18'h00003, 16'h0000, 1'b0,1'b0, 16'h0000, 4'd5}, // R5 read no lanes
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'h8877, 4'd5}, // R5 word unchanged
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 18'h00043, 16'h1234, 1'b0,1'b0, 16'h0000, 4'd8}, // R8 alias write
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'h1234, 4'd8}, // R8 seen at base
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h20003, 16'h0000, 1'b1,1'b1, 16'h1234, 4'd8}, // R8 top bit ignored
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 18'h0000A, 16'hBEEF, 1'b0,1'b0, 16'h0000, 4'd6}, // R6 other word
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h0000A, 16'h0000, 1'b1,1'b1, 16'hBEEF, 4'd9}, // R9
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 18'h00003, 16'h0000, 1'b1,1'b1, 16'h1234, 4'd6}  // R6 words independent
  };

  task automatic check(input bit ok, input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1;
    addr = '0; wdata = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!drv_lo && !drv_hi, 1, {14'd0, drv_hi, drv_lo}, 16'h0000);
    check(rdata == 16'h0000, 1, rdata, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      sel_n = TBL[i].sel_n; oe_n = TBL[i].oe_n; we_n = TBL[i].we_n;
      lo_n = TBL[i].lo_n; hi_n = TBL[i].hi_n;
      addr = TBL[i].addr; wdata = TBL[i].wd;
      @(posedge clk);
      #1;
      check(drv_lo == TBL[i].elo && drv_hi == TBL[i].ehi, int'(TBL[i].req),
            {14'd0, drv_hi, drv_lo}, {14'd0, TBL[i].ehi, TBL[i].elo});
      if (TBL[i].elo)
        check(rdata[7:0] == TBL[i].ed[7:0], int'(TBL[i].req), {8'h00, rdata[7:0]}, {8'h00, TBL[i].ed[7:0]});
      if (TBL[i].ehi)
        check(rdata[15:8] == TBL[i].ed[15:8], int'(TBL[i].req), {rdata[15:8], 8'h00}, {TBL[i].ed[15:8], 8'h00});
    end

    // R7: write with oe_n high and only upper lane, then full read
    sel_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; lo_n = 1'b1; hi_n = 1'b0;
    addr = 18'h0000A; wdata = 16'h5A00;
    @(posedge clk); #1;
    check(!drv_lo && !drv_hi, 7, {14'd0, drv_hi, drv_lo}, 16'h0000);
    oe_n = 1'b0; we_n = 1'b1; lo_n = 1'b0; hi_n = 1'b0;
    @(posedge clk); #1;
    check(rdata == 16'h5AEF, 7, rdata, 16'h5AEF);

    // R1: reset during an active read clears outputs
    rst = 1'b1;
    @(posedge clk); #1;
    check(!drv_lo && !drv_hi, 1, {14'd0, drv_hi, drv_lo}, 16'h0000);
    check(rdata == 16'h0000, 1, rdata, 16'h0000);
    rst = 1'b0;
    idle();
    @(posedge clk); #1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule